// File: doc/BRIEF.md
# Receive Completion Event Coalescer

This block sits beside one receive completion ring and decides when software should be told about new work. Every time the receive engine writes a completion entry it pulses a strobe, and the block adds one to a count of entries that software has not yet consumed. Software drains that count by writing how many packets it has processed. The event output rises when the count exceeds a programmable threshold. It also rises when a programmable timeout expires while at least one entry is pending, so a lone frame is never stranded below the threshold.

The timeout runs in coarse ticks. A programmable divider of the core clock sets the tick length. The countdown is held reloaded while nothing is pending and starts from its full value as soon as the count leaves zero. A timeout latches a status bit that stays set until software clears it. An acknowledgement larger than the pending count floors the count at zero and raises a sticky error flag.

Register map on `regAddr`: 0 divider, 1 threshold, 2 timeout setup, 3 acknowledge, 4 status clear.

Top module: `rxc_coalescer`

## Requirements
- R1: After reset the pending count is 0, and `eventOut`, `toStatus` and `ackErr` are all low. The threshold is 0, the timeout is disabled and the divider is 1.
- R2: Each cycle with `cmplStrobe` high raises the pending count by one on the next edge. The count holds at its maximum, 2^CNT_W-1, and does not wrap.
- R3: A write to address 3 subtracts `regWrData` from the pending count. A completion in the same cycle is netted against it, so pending 2 with one completion and an acknowledgement of 1 gives 2.
- R4: If an acknowledgement exceeds the pending count plus any same-cycle completion, the count becomes 0 and `ackErr` is set. `ackErr` stays set until a write to address 4 with bit 1 high.
- R5: With the threshold (address 1, bits 8:0) nonzero, `eventOut` is high in every cycle in which the pending count is strictly greater than the threshold. A threshold of 0 disables this trigger.
- R6: With the timeout enabled (address 2, bit 15) and its value V (address 2, bits 5:0) nonzero, and with divider D (address 0, where 0 acts as 1), `toStatus` sets exactly V*D cycles after the edge on which the pending count leaves zero, provided the count stays nonzero.
- R7: Whenever the pending count returns to zero, the timeout countdown and its prescaler are discarded. The next pending entry starts a full V*D interval.
- R8: `toStatus` is sticky and forces `eventOut` high. A write to address 4 with bit 0 high clears it.
- R9: With the enable bit low, or with V equal to 0, `toStatus` never sets, however long entries stay pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmplStrobe | input | 1 | One completion entry written this cycle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 16 | Register write data |
| eventOut | output | 1 | Coalesced event request |
| pendCount | output | CNT_W | Completion entries not yet acknowledged |
| toStatus | output | 1 | Latched timeout status |
| ackErr | output | 1 | Sticky over-acknowledge flag |

## Verification
A wrong pending count shows on `pendCount` on the edge after the strobe or write that caused it. It also moves the threshold crossing on `eventOut` by the same number of entries. A countdown or prescaler that was not reloaded, or that started late, moves the rise of `toStatus` away from exactly V*D cycles. The bench therefore checks that `toStatus` is still low one cycle before that point and high at it. A flag that loses its stickiness, or that clears from the wrong bit, shows in the first cycle after the stimulus.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int DATA_W = 16;
  localparam int THR_W  = 9;
  localparam int TOV_W  = 6;
  localparam int TO_EN_BIT = 15;

  localparam logic [2:0] ADDR_DIV = 3'd0;
  localparam logic [2:0] ADDR_THR = 3'd1;
  localparam logic [2:0] ADDR_TOV = 3'd2;
  localparam logic [2:0] ADDR_ACK = 3'd3;
  localparam logic [2:0] ADDR_CLR = 3'd4;

  typedef struct packed {
    logic ackEn;
    logic toFire;
    logic clrTo;
    logic clrErr;
  } rxc_strobe_t;
endpackage

// File: rtl/rxc_ctrl.sv
module rxc_ctrl
  import rxc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              pendNZ,
  output rxc_strobe_t       strobes,
  output logic [THR_W-1:0]  thrVal,
  output logic [DATA_W-1:0] ackAmt
);
  logic [DATA_W-1:0] divReg;
  logic [TOV_W-1:0]  tovReg;
  logic              toEnReg;
  logic [DATA_W-1:0] presc;
  logic [TOV_W-1:0]  timer;
  logic [DATA_W-1:0] divM1;
  logic              armed;
  logic              tick;

  wire wrDiv = regWrEn && (regAddr == ADDR_DIV);
  wire wrThr = regWrEn && (regAddr == ADDR_THR);
  wire wrTov = regWrEn && (regAddr == ADDR_TOV);
  wire wrAck = regWrEn && (regAddr == ADDR_ACK);
  wire wrClr = regWrEn && (regAddr == ADDR_CLR);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg  <= DATA_W'(1);
      thrVal  <= '0;
      tovReg  <= '0;
      toEnReg <= 1'b0;
    end else begin
      if (wrDiv) divReg <= regWrData;
      if (wrThr) thrVal <= regWrData[THR_W-1:0];
      if (wrTov) begin
        tovReg  <= regWrData[TOV_W-1:0];
        toEnReg <= regWrData[TO_EN_BIT];
      end
    end
  end

  // prescaler and countdown, idle while nothing is pending
  always_comb begin
    divM1 = (divReg == '0) ? '0 : divReg - DATA_W'(1);
    armed = toEnReg && (tovReg != '0) && pendNZ;
    tick  = armed && (presc >= divM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
      timer <= '0;
    end else if (!armed) begin
      presc <= '0;
      timer <= tovReg;
    end else if (tick) begin
      presc <= '0;
      timer <= (timer <= TOV_W'(1)) ? tovReg : timer - TOV_W'(1);
    end else begin
      presc <= presc + DATA_W'(1);
    end
  end

  always_comb begin
    strobes.ackEn  = wrAck;
    strobes.toFire = tick && (timer <= TOV_W'(1));
    strobes.clrTo  = wrClr && regWrData[0];
    strobes.clrErr = wrClr && regWrData[1];
    ackAmt         = regWrData;
  end

  AST_TO_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!toEnReg || tovReg == '0) |-> !strobes.toFire) else $error("to fire while off"); // R9
endmodule

// File: rtl/rxc_datapath.sv
module rxc_datapath
  import rxc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmplStrobe,
  input  rxc_strobe_t       strobes,
  input  logic [THR_W-1:0]  thrVal,
  input  logic [DATA_W-1:0] ackAmt,
  output logic [CNT_W-1:0]  pendCount,
  output logic              pendNZ,
  output logic              toStatus,
  output logic              ackErr,
  output logic              eventOut
);
  localparam int SW = ((CNT_W > DATA_W) ? CNT_W : DATA_W) + 2;
  localparam logic [SW-1:0] CNT_MAX = SW'({CNT_W{1'b1}});

  logic [SW-1:0]    incSum;
  logic [SW-1:0]    ackW;
  logic [SW-1:0]    netSum;
  logic             underflow;
  logic [CNT_W-1:0] nextPend;
  logic             thrHit;

  always_comb begin
    incSum    = SW'(pendCount) + SW'(cmplStrobe);
    ackW      = strobes.ackEn ? SW'(ackAmt) : '0;
    underflow = ackW > incSum;
    netSum    = underflow ? '0 : incSum - ackW;
    nextPend  = (netSum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : netSum[CNT_W-1:0];
    pendNZ    = (pendCount != '0);
    thrHit    = (thrVal != '0) && (SW'(pendCount) > SW'(thrVal));
    eventOut  = thrHit || toStatus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCount <= '0;
      toStatus  <= 1'b0;
      ackErr    <= 1'b0;
    end else begin
      pendCount <= nextPend;
      if (strobes.toFire)     toStatus <= 1'b1;
      else if (strobes.clrTo) toStatus <= 1'b0;
      if (underflow)           ackErr <= 1'b1;
      else if (strobes.clrErr) ackErr <= 1'b0;
    end
  end

  AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmplStrobe && !strobes.ackEn && pendCount != CNT_MAX[CNT_W-1:0]) |=>
      (pendCount == $past(pendCount) + CNT_W'(1))) else $error("step"); // R2
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmplStrobe && !strobes.ackEn) |=> $stable(pendCount)) else $error("hold"); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ackErr && !strobes.clrErr) |=> ackErr) else $error("err sticky"); // R4
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (toStatus && !strobes.clrTo) |=> toStatus) else $error("to sticky"); // R8
  AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == '0) |-> !strobes.toFire) else $error("fire idle"); // R7
endmodule

// File: rtl/rxc_coalescer.sv
module rxc_coalescer
  import rxc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmplStrobe,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [15:0]      regWrData,
  output logic             eventOut,
  output logic [CNT_W-1:0] pendCount,
  output logic             toStatus,
  output logic             ackErr
);
  rxc_strobe_t       strobes;
  logic [THR_W-1:0]  thrVal;
  logic [DATA_W-1:0] ackAmt;
  logic              pendNZ;

  rxc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pendNZ(pendNZ), .strobes(strobes),
    .thrVal(thrVal), .ackAmt(ackAmt)
  );

  rxc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmplStrobe(cmplStrobe), .strobes(strobes),
    .thrVal(thrVal), .ackAmt(ackAmt), .pendCount(pendCount), .pendNZ(pendNZ),
    .toStatus(toStatus), .ackErr(ackErr), .eventOut(eventOut)
  );
endmodule

// File: tb/rxc_coalescer_tb.sv
module rxc_coalescer_tb;
  localparam int CNT_W = 12;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmplStrobe = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic eventOut, toStatus, ackErr;
  logic [CNT_W-1:0] pendCount;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rxc_coalescer #(.CNT_W(CNT_W)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d, bit withCmpl = 1'b0);
    regWrEn = 1'b1; regAddr = a; regWrData = d; cmplStrobe = withCmpl;
    step();
    regWrEn = 1'b0; cmplStrobe = 1'b0;
  endtask

  task automatic cmpl(int n);
    cmplStrobe = 1'b1;
    step(n);
    cmplStrobe = 1'b0;
  endtask

  task automatic drain();
    wr(3'd3, 16'(pendCount));
    wr(3'd4, 16'h3);
  endtask

  task automatic t_reset();
    chk("R1 pend", int'(pendCount), 0);
    chk("R1 event", int'(eventOut), 0);
    chk("R1 toStatus", int'(toStatus), 0);
    chk("R1 ackErr", int'(ackErr), 0);
  endtask

  task automatic t_count();
    cmpl(5);
    chk("R2 count 5", int'(pendCount), 5);
    wr(3'd3, 16'd2);
    chk("R3 ack 2", int'(pendCount), 3);
    wr(3'd3, 16'd1, 1'b1);
    chk("R3 net cmpl+ack", int'(pendCount), 3);
    wr(3'd3, 16'd4, 1'b1);
    chk("R3 net to zero", int'(pendCount), 0);
    chk("R3 no error", int'(ackErr), 0);
  endtask

  task automatic t_saturate();
    cmpl(4100);
    chk("R2 saturate", int'(pendCount), 4095);
    cmpl(1);
    chk("R2 hold max", int'(pendCount), 4095);
    wr(3'd3, 16'd1, 1'b1);
    chk("R3 net at max", int'(pendCount), 4095);
    drain();
    chk("R3 drained", int'(pendCount), 0);
  endtask

  task automatic t_overack();
    cmpl(2);
    wr(3'd3, 16'd5);
    chk("R4 floor zero", int'(pendCount), 0);
    chk("R4 err set", int'(ackErr), 1);
    cmpl(1);
    chk("R4 err sticky", int'(ackErr), 1);
    wr(3'd4, 16'h1);
    chk("R4 wrong bit keeps err", int'(ackErr), 1);
    wr(3'd4, 16'h2);
    chk("R4 err cleared", int'(ackErr), 0);
    drain();
  endtask

  task automatic t_threshold();
    wr(3'd1, 16'd3);
    cmpl(3);
    chk("R5 at thr no event", int'(eventOut), 0);
    cmpl(1);
    chk("R5 above thr event", int'(eventOut), 1);
    wr(3'd3, 16'd1);
    chk("R5 back to thr", int'(eventOut), 0);
    wr(3'd1, 16'd0);
    cmpl(2);
    chk("R5 thr zero disables", int'(eventOut), 0);
    drain();
  endtask

  task automatic t_timeout();
    wr(3'd0, 16'd3);
    wr(3'd2, 16'h8004);
    cmpl(1);
    step(11);
    chk("R6 not yet", int'(toStatus), 0);
    step(1);
    chk("R6 fires at V*D", int'(toStatus), 1);
    chk("R8 drives event", int'(eventOut), 1);
    wr(3'd3, 16'd1);
    step(20);
    chk("R8 sticky", int'(toStatus), 1);
    wr(3'd4, 16'h1);
    chk("R8 cleared", int'(toStatus), 0);
    chk("R8 event low", int'(eventOut), 0);
  endtask

  task automatic t_reload();
    wr(3'd0, 16'd2);
    wr(3'd2, 16'h8005);
    cmpl(1);
    step(6);
    wr(3'd3, 16'd1);
    cmpl(1);
    step(9);
    chk("R7 full interval early", int'(toStatus), 0);
    step(1);
    chk("R7 full interval fire", int'(toStatus), 1);
    drain();
    wr(3'd0, 16'd0);
    wr(3'd2, 16'h8003);
    cmpl(1);
    step(2);
    chk("R6 div zero early", int'(toStatus), 0);
    step(1);
    chk("R6 div zero as one", int'(toStatus), 1);
    drain();
  endtask

  task automatic t_disabled();
    wr(3'd0, 16'd1);
    wr(3'd2, 16'h0002);
    cmpl(1);
    step(40);
    chk("R9 enable low", int'(toStatus), 0);
    wr(3'd2, 16'h8000);
    step(40);
    chk("R9 value zero", int'(toStatus), 0);
    drain();
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    t_reset();
    t_count();
    t_saturate();
    t_overack();
    t_threshold();
    t_timeout();
    t_reload();
    t_disabled();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule